// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block selects the reply that a full-speed USB control endpoint gives to each token or packet that the receive path has already decoded. It holds the endpoint's receive and transmit status fields, the sticky receive-complete flag and the two data toggles. For every transaction the receive path presents, it picks one handshake: ACK, NAK, STALL or silence. It also raises strobes that tell the packet buffer to keep incoming data, or to start sending data for an IN.

Software loads both status fields with a single write strobe and clears the receive-complete flag with a dedicated pulse. SETUP packets are handled apart from OUT and IN. A SETUP is never refused with NAK or STALL. It is dropped in silence only when an earlier reception is still unacknowledged, so that the notification of that reception is not lost. When the status-out qualifier is high, an OUT carrying a nonzero payload is flagged as a protocol error.

Top module: `ctl_ep_responder`

## Requirements
- R1: After reset both status fields are 00 (disabled), the receive-complete flag and both toggles are 0, and every output strobe is 0. Status encoding is 00 disabled, 01 STALL, 10 NAK, 11 VALID.
- R2: When the status field for a transaction's direction is disabled, the endpoint sends no handshake (hs_code 00), accepts nothing and raises no strobe. The receive field governs SETUP and OUT; the transmit field governs IN. Token encoding is 01 OUT, 10 IN, 11 SETUP.
- R3: A good-CRC SETUP on an enabled endpoint with no pending reception is answered with ACK (hs_code 01), whatever the receive field holds (STALL, NAK or VALID). It also raises rx_accept and done_set. A SETUP is never answered with NAK (10) or STALL (11).
- R4: A SETUP that arrives while rx_done is set is discarded. There is no handshake and no accept, and the status fields and flag are left unchanged.
- R5: After an ACKed SETUP, both status fields read 10 (NAK) and both toggles read 1.
- R6: An OUT is answered with STALL or NAK when the receive field is STALL or NAK, and its data is not accepted.
- R7: An OUT on a VALID receive field is answered with ACK. It raises rx_accept and done_set, sets rx_done and inverts rx_tog.
- R8: When stat_out_qual is 1, an OUT on a VALID receive field with a nonzero pkt_len raises proto_err, gets no handshake and is not accepted. A zero-length OUT is accepted as in R7.
- R9: An IN is answered with STALL or NAK when the transmit field holds that value. When the transmit field is VALID, the endpoint raises in_send instead of a handshake and inverts tx_tog.
- R10: A SETUP or OUT with crc_ok low gets no handshake and does not set rx_done.
- R11: rx_done stays set until a done_clr pulse. When a new reception and done_clr fall in the same cycle, the reception wins.
- R12: Results appear in the cycle after tok_valid and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tok_valid | input | 1 | One-cycle strobe: a decoded transaction is present |
| tok_kind | input | 2 | 01 OUT, 10 IN, 11 SETUP |
| pkt_len | input | LEN_W | Received data length in bytes |
| crc_ok | input | 1 | Data packet CRC was good |
| stat_out_qual | input | 1 | Expect a zero-length OUT status stage |
| stat_wr | input | 1 | Load both status fields |
| rx_stat_wr | input | 2 | New receive status |
| tx_stat_wr | input | 2 | New transmit status |
| done_clr | input | 1 | Clear the receive-complete flag |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |
| rx_accept | output | 1 | Keep the received data |
| done_set | output | 1 | Pulse: receive-complete flag being set |
| in_send | output | 1 | Pulse: transmit buffered data for an IN |
| proto_err | output | 1 | Nonzero-length status OUT |
| rx_stat | output | 2 | Current receive status |
| tx_stat | output | 2 | Current transmit status |
| rx_done | output | 1 | Receive-complete flag |
| rx_tog | output | 1 | Receive data toggle |
| tx_tog | output | 1 | Transmit data toggle |

## Verification
The bench builds the block with LEN_W at its default of 7, so pkt_len reaches 127. That width is enough to give the status-out check both a zero and a nonzero payload. Every pairing of token and status encoding is driven with a cleared receive-complete flag. Directed sequences then leave that flag set, to cover the silent SETUP drop and the case where clear and set collide.

// File: rtl/ctl_ep_responder.sv
module ctl_ep_responder #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             crc_ok,
  input  logic             stat_out_qual,
  input  logic             stat_wr,
  input  logic [1:0]       rx_stat_wr,
  input  logic [1:0]       tx_stat_wr,
  input  logic             done_clr,
  output logic [1:0]       hs_code,
  output logic             rx_accept,
  output logic             done_set,
  output logic             in_send,
  output logic             proto_err,
  output logic [1:0]       rx_stat,
  output logic [1:0]       tx_stat,
  output logic             rx_done,
  output logic             rx_tog,
  output logic             tx_tog
);
  localparam logic [1:0] ST_DIS = 2'b00, ST_STALL = 2'b01, ST_NAK = 2'b10, ST_VALID = 2'b11;
  localparam logic [1:0] K_OUT = 2'b01, K_IN = 2'b10, K_SETUP = 2'b11;
  localparam logic [1:0] HS_NONE = 2'b00, HS_ACK = 2'b01, HS_NAK = 2'b10, HS_STALL = 2'b11;

  logic [1:0] n_hs;
  logic       n_acc, n_ins, n_err, setup_ok, out_ok;
  wire        len_nz = (pkt_len != '0);

  always_comb begin
    n_hs = HS_NONE;
    n_acc = 1'b0;
    n_ins = 1'b0;
    n_err = 1'b0;
    setup_ok = 1'b0;
    out_ok = 1'b0;
    if (tok_valid) begin
      case (tok_kind)
        K_SETUP:
          if (rx_stat != ST_DIS && crc_ok && !rx_done) begin
            n_hs = HS_ACK;
            n_acc = 1'b1;
            setup_ok = 1'b1;
          end
        K_OUT:
          if (crc_ok) begin
            case (rx_stat)
              ST_STALL: n_hs = HS_STALL;
              ST_NAK:   n_hs = HS_NAK;
              ST_VALID:
                if (stat_out_qual && len_nz) n_err = 1'b1;
                else begin
                  n_hs = HS_ACK;
                  n_acc = 1'b1;
                  out_ok = 1'b1;
                end
              default: ;
            endcase
          end
        K_IN:
          case (tx_stat)
            ST_STALL: n_hs = HS_STALL;
            ST_NAK:   n_hs = HS_NAK;
            ST_VALID: n_ins = 1'b1;
            default: ;
          endcase
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_code   <= HS_NONE;
      rx_accept <= 1'b0;
      done_set  <= 1'b0;
      in_send   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      hs_code   <= n_hs;
      rx_accept <= n_acc;
      done_set  <= n_acc;
      in_send   <= n_ins;
      proto_err <= n_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_stat <= ST_DIS;
      tx_stat <= ST_DIS;
      rx_done <= 1'b0;
      rx_tog  <= 1'b0;
      tx_tog  <= 1'b0;
    end else begin
      rx_done <= n_acc | (rx_done & ~done_clr);
      if (stat_wr) begin
        rx_stat <= rx_stat_wr;
        tx_stat <= tx_stat_wr;
      end else if (setup_ok) begin
        rx_stat <= ST_NAK;
        tx_stat <= ST_NAK;
      end
      if (setup_ok) begin
        rx_tog <= 1'b1;
        tx_tog <= 1'b1;
      end else begin
        if (out_ok) rx_tog <= ~rx_tog;
        if (n_ins)  tx_tog <= ~tx_tog;
      end
    end
  end

  // R3
  setup_no_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_kind == K_SETUP |=> hs_code != HS_NAK && hs_code != HS_STALL);

  // R4
  setup_pending_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_kind == K_SETUP && rx_done |=> hs_code == HS_NONE && !rx_accept);

  // R5
  setup_naks_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_kind == K_SETUP && rx_stat != ST_DIS && crc_ok && !rx_done && !stat_wr
    |=> rx_stat == ST_NAK && tx_stat == ST_NAK && rx_tog && tx_tog);

  // R8
  status_out_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_kind == K_OUT && rx_stat == ST_VALID && crc_ok && stat_out_qual && len_nz
    |=> proto_err && hs_code == HS_NONE && !rx_accept);

  // R10
  crc_bad_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && (tok_kind == K_OUT || tok_kind == K_SETUP) && !crc_ok
    |=> hs_code == HS_NONE && !done_set);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !done_clr |=> rx_done);

  // R7
  accept_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> rx_done);
endmodule

// File: tb/ctl_ep_responder_bench.sv
module ctl_ep_responder_bench;
  localparam int LW = 7;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 1'b0, crc_ok = 1'b0, stat_out_qual = 1'b0, stat_wr = 1'b0, done_clr = 1'b0;
  logic [1:0] tok_kind = 2'b00, rx_stat_wr = 2'b00, tx_stat_wr = 2'b00;
  logic [LW-1:0] pkt_len = '0;
  logic [1:0] hs_code, rx_stat, tx_stat;
  logic rx_accept, done_set, in_send, proto_err, rx_done, rx_tog, tx_tog;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ctl_ep_responder #(.LEN_W(LW)) u_ctl_ep_responder (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind), .pkt_len(pkt_len),
    .crc_ok(crc_ok), .stat_out_qual(stat_out_qual), .stat_wr(stat_wr), .rx_stat_wr(rx_stat_wr),
    .tx_stat_wr(tx_stat_wr), .done_clr(done_clr), .hs_code(hs_code), .rx_accept(rx_accept),
    .done_set(done_set), .in_send(in_send), .proto_err(proto_err), .rx_stat(rx_stat),
    .tx_stat(tx_stat), .rx_done(rx_done), .rx_tog(rx_tog), .tx_tog(tx_tog));

  // {rx, tx, kind, len, crc, qual, exp_hs, exp_acc, exp_done, exp_ins, exp_err}
  localparam logic [20:0] VEC [NV] = '{
    {2'b00, 2'b11, 2'b11, 7'd8, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    {2'b01, 2'b01, 2'b11, 7'd8, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    {2'b10, 2'b10, 2'b11, 7'd8, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    {2'b11, 2'b11, 2'b11, 7'd8, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    {2'b10, 2'b10, 2'b11, 7'd8, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
    {2'b11, 2'b11, 2'b01, 7'd8, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
    {2'b10, 2'b11, 2'b01, 7'd8, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    {2'b01, 2'b11, 2'b01, 7'd8, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    {2'b11, 2'b11, 2'b01, 7'd8, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0}, // R7
    {2'b11, 2'b11, 2'b01, 7'd5, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
    {2'b11, 2'b11, 2'b01, 7'd0, 1'b1, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0}, // R8
    {2'b11, 2'b10, 2'b10, 7'd0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
    {2'b11, 2'b01, 2'b10, 7'd0, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
    {2'b11, 2'b11, 2'b10, 7'd0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0}, // R9
    {2'b11, 2'b00, 2'b10, 7'd0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    {2'b00, 2'b11, 2'b01, 7'd8, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    {2'b11, 2'b11, 2'b10, 7'd0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] rx, input logic [1:0] tx);
    stat_wr = 1'b1; rx_stat_wr = rx; tx_stat_wr = tx; done_clr = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0; done_clr = 1'b0;
  endtask

  task automatic send(input logic [1:0] k, input logic [LW-1:0] len, input logic crc, input logic q);
    tok_valid = 1'b1; tok_kind = k; pkt_len = len; crc_ok = crc; stat_out_qual = q;
    @(negedge clk);
    tok_valid = 1'b0; done_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1", {rx_stat, tx_stat, rx_done, rx_tog, tx_tog, hs_code, rx_accept, done_set, in_send, proto_err},
          32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      load(v[20:19], v[18:17]);
      send(v[16:15], v[14:8], v[7], v[6]);
      check($sformatf("vector %0d (R2/R3/R6-R10)", i),
            {hs_code, rx_accept, done_set, in_send, proto_err, rx_done},
            {v[5:4], v[3], v[2], v[1], v[0], v[2]});
    end

    // R12: pulses last one cycle
    load(2'b11, 2'b11);
    send(2'b01, 7'd3, 1'b1, 1'b0);
    check("R12 pulse", {hs_code, rx_accept}, {2'b01, 1'b1});
    @(negedge clk);
    check("R12 pulse end", {hs_code, rx_accept, done_set, in_send, proto_err}, 6'd0);

    // R5
    load(2'b11, 2'b11);
    send(2'b11, 7'd8, 1'b1, 1'b0);
    check("R5", {rx_stat, tx_stat, rx_tog, tx_tog}, {2'b10, 2'b10, 1'b1, 1'b1});

    // R7 and R9 toggles
    load(2'b11, 2'b11);
    send(2'b01, 7'd2, 1'b1, 1'b0);
    check("R7 rx_tog", rx_tog, 1'b0);
    send(2'b10, 7'd0, 1'b1, 1'b0);
    check("R9 tx_tog", tx_tog, 1'b0);

    // R4: pending reception drops SETUP
    load(2'b11, 2'b11);
    send(2'b01, 7'd4, 1'b1, 1'b0);
    check("R4 setup pending", rx_done, 1'b1);
    send(2'b11, 7'd8, 1'b1, 1'b0);
    check("R4", {hs_code, rx_accept, rx_stat, tx_stat, rx_done}, {2'b00, 1'b0, 2'b11, 2'b11, 1'b1});

    // R11
    repeat (3) @(negedge clk);
    check("R11 held", rx_done, 1'b1);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    check("R11 cleared", rx_done, 1'b0);
    done_clr = 1'b1;
    send(2'b01, 7'd1, 1'b1, 1'b0);
    check("R11 set wins", rx_done, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule